// File: doc/BRIEF.md
# DDR Read Capture with Half-Rate Widening

This block takes a double-data-rate read stream arriving on one or more DQ lines, together with the read strobe and its complement. It captures one bit on each strobe edge and lines the two bits of a strobe period up into a single pair. It then carries that pair into a full-rate resynchronization clock domain. A final stage joins two consecutive full-rate pairs into one four-bit word per lane, clocked by a half-rate resynchronization clock.

Every register after the first capture flop can be skipped by a static bypass control: the pair alignment, the full-rate resync and the half-rate output register. A phase input chooses which full-rate cycle begins a half-rate word. A runtime select steers data either to the half-rate word port or to the full-rate pair port, and drives the unused port to zero. The half-rate clock runs at exactly half the full-rate clock, with its rising edges on full-rate rising edges. Each clock domain has a synchronous active-high reset.

Throughout, "pair n" means the bit sampled on strobe rising edge n and the bit sampled on the falling edge that follows it. Packed pairs place the rising bit in bit 0 and the falling bit in bit 1. The latencies below assume the relation used in operation: strobe rising edge n comes a quarter period after full-rate edge n. L is the pair latency, 3 with nothing bypassed and one less for each of the alignment and resync stages bypassed.

Top module: `ddrc_read_capture`

## Requirements
- R1: With no stage bypassed and the full-rate port selected, q_fr just before full-rate edge k equals pair k-3 (bit 0 rising bit, bit 1 falling bit).
- R2: Bypassing the alignment stage (skip_align=1) shortens the pair latency by one full-rate cycle, leaving bit order and content unchanged.
- R3: Bypassing the full-rate resync register (skip_resync=1) shortens the pair latency by one full-rate cycle, leaving bit order and content unchanged.
- R4: With the half-rate register in use and hr_phase=0, q_hr just before a half-rate rising edge at full-rate edge k is {newer, older}. Here newer is pair k-L-2 in bits [3:2] and older is the pair before it in bits [1:0], each with its rising bit in the lower position.
- R5: With skip_hr=1, the half-rate word is presented without the output register, so the newer pair index becomes k-L-hr_phase.
- R6: hr_phase=1 shifts each half-rate word one full-rate cycle later: both pairs in the word are one index older than with hr_phase=0.
- R7: sel_fr=1 routes the full-rate pair to q_fr and forces q_hr to zero. sel_fr=0 routes the word to q_hr and forces q_fr to zero. A change of sel_fr takes effect at the ports without waiting for a clock edge.
- R8: Holding rst high across at least two edges of every clock clears all registers, so both output ports read zero whatever sel_fr is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| strb_clk | input | 1 | Read strobe; rising edge captures the first bit of a pair |
| strb_n_clk | input | 1 | Complementary strobe; rising edge captures the second bit |
| fr_clk | input | 1 | Full-rate resynchronization clock |
| hr_clk | input | 1 | Half-rate resynchronization clock, edge-aligned with fr_clk |
| rst | input | 1 | Synchronous active-high reset, sampled in every domain |
| dq | input | DQ_W | DDR read data |
| skip_align | input | 1 | Static: bypass the pair alignment registers |
| skip_resync | input | 1 | Static: bypass the full-rate resync register |
| skip_hr | input | 1 | Static: bypass the half-rate output register |
| hr_phase | input | 1 | Static: full-rate cycle on which a half-rate word starts |
| sel_fr | input | 1 | Runtime: 1 selects the full-rate port, 0 the half-rate port |
| q_hr | output | 4*DQ_W | Half-rate word {newer fall, newer rise, older fall, older rise} |
| q_fr | output | 2*DQ_W | Full-rate pair {fall, rise} |

## Verification
Each result has a fixed due time. The full-rate pair is due L full-rate cycles after its strobe period. The half-rate word is due L+2+hr_phase cycles after its newer pair, or L+hr_phase cycles with the output register bypassed. The bench drives a pseudo-random bit stream with the strobe centred in each bit and records every driven pair in order. It samples both ports half a nanosecond before each full-rate edge and compares them with the recorded pair at the index the latency formula gives. Half-rate words are compared only just before half-rate edges. After every change of the static controls, comparison pauses for twelve full-rate cycles so that no stale data is judged. All sixteen combinations of the three bypasses and the phase are covered, with the select toggled inside each.

// File: rtl/ddrc_pkg.sv
package ddrc_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  // Which full-rate cycle opens a half-rate word.
  typedef enum logic {
    PH_EVEN = 1'b0,
    PH_ODD  = 1'b1
  } hr_phase_e;

  // Full-rate cycles from a strobe period to the full-rate port.
  function automatic int unsigned pair_latency(input logic skip_align,
                                               input logic skip_resync);
    int unsigned lat;
    lat = 1;
    if (!skip_align)  lat = lat + 1;
    if (!skip_resync) lat = lat + 1;
    return lat;
  endfunction

  // Full-rate cycles from the newer pair of a word to the half-rate port.
  function automatic int unsigned word_latency(input logic skip_align,
                                               input logic skip_resync,
                                               input logic skip_hr,
                                               input logic phase);
    int unsigned lat;
    lat = pair_latency(skip_align, skip_resync) + int'(phase);
    if (!skip_hr) lat = lat + 2;
    return lat;
  endfunction
endpackage

// File: rtl/ddrc_strobe_capture.sv
module ddrc_strobe_capture #(
  parameter int DQ_W = 1
) (
  input  logic              strb_clk,
  input  logic              strb_n_clk,
  input  logic              rst,
  input  logic              skip_align,
  input  logic [DQ_W-1:0]   dq,
  output logic [DQ_W-1:0]   rise_raw,
  output logic [DQ_W-1:0]   fall_raw,
  output logic [DQ_W-1:0]   rise_al,
  output logic [DQ_W-1:0]   fall_al,
  output logic [2*DQ_W-1:0] pair_s
);
  timeunit 1ns;
  timeprecision 1ps;

  for (genvar ln = 0; ln < DQ_W; ln++) begin : g_lane
    logic rise_q;
    logic fall_q;
    logic rise_al_q;
    logic fall_al_q;

    // First capture flop: never bypassed.
    always_ff @(posedge strb_clk) begin
      if (rst) rise_q <= 1'b0;
      else     rise_q <= dq[ln];
    end

    // Second bit of the period, on the complementary strobe.
    always_ff @(posedge strb_n_clk) begin
      if (rst) fall_q <= 1'b0;
      else     fall_q <= dq[ln];
    end

    // On the next rising strobe edge both bits move together.
    always_ff @(posedge strb_clk) begin
      if (rst) begin
        rise_al_q <= 1'b0;
        fall_al_q <= 1'b0;
      end else begin
        rise_al_q <= rise_q;
        fall_al_q <= fall_q;
      end
    end

    assign rise_raw[ln] = rise_q;
    assign fall_raw[ln] = fall_q;
    assign rise_al[ln]  = rise_al_q;
    assign fall_al[ln]  = fall_al_q;
  end

  always_comb begin
    if (skip_align) pair_s = {fall_raw, rise_raw};
    else            pair_s = {fall_al, rise_al};
  end
endmodule

// File: rtl/ddrc_resync.sv
module ddrc_resync #(
  parameter int DQ_W = 1
) (
  input  logic              fr_clk,
  input  logic              rst,
  input  logic              skip_resync,
  input  logic [2*DQ_W-1:0] pair_s,
  output logic [2*DQ_W-1:0] rs_q,
  output logic [2*DQ_W-1:0] cur_pair
);
  timeunit 1ns;
  timeprecision 1ps;

  always_ff @(posedge fr_clk) begin
    if (rst) rs_q <= '0;
    else     rs_q <= pair_s;
  end

  always_comb begin
    if (skip_resync) cur_pair = pair_s;
    else             cur_pair = rs_q;
  end
endmodule

// File: rtl/ddrc_halfrate.sv
module ddrc_halfrate #(
  parameter int DQ_W = 1
) (
  input  logic              fr_clk,
  input  logic              hr_clk,
  input  logic              rst,
  input  logic              skip_hr,
  input  logic              hr_phase,
  input  logic [2*DQ_W-1:0] cur_pair,
  output logic [2*DQ_W-1:0] hist_new,
  output logic [2*DQ_W-1:0] hist_old,
  output logic [4*DQ_W-1:0] word
);
  timeunit 1ns;
  timeprecision 1ps;
  import ddrc_pkg::*;

  localparam int PAIR_W = 2 * DQ_W;
  localparam int WORD_W = 2 * PAIR_W;
  localparam int HIST   = 2;

  logic [HIST-1:0][PAIR_W-1:0] hist_q;
  logic [WORD_W-1:0]           word_c;
  logic [WORD_W-1:0]           word_q;
  hr_phase_e                   ph;

  // Newer pair occupies the upper half of the word.
  function automatic logic [WORD_W-1:0] join_pairs(input logic [PAIR_W-1:0] older,
                                                   input logic [PAIR_W-1:0] newer);
    return {newer, older};
  endfunction

  always_ff @(posedge fr_clk) begin
    if (rst) begin
      hist_q <= '0;
    end else begin
      hist_q[0] <= cur_pair;
      for (int k = 1; k < HIST; k++) hist_q[k] <= hist_q[k-1];
    end
  end

  assign ph = hr_phase_e'(hr_phase);

  always_comb begin
    unique case (ph)
      PH_ODD:  word_c = join_pairs(hist_q[1], hist_q[0]);
      default: word_c = join_pairs(hist_q[0], cur_pair);
    endcase
  end

  always_ff @(posedge hr_clk) begin
    if (rst) word_q <= '0;
    else     word_q <= word_c;
  end

  assign word     = skip_hr ? word_c : word_q;
  assign hist_new = hist_q[0];
  assign hist_old = hist_q[1];
endmodule

// File: rtl/ddrc_read_capture.sv
module ddrc_read_capture #(
  parameter int DQ_W = 1
) (
  input  logic              strb_clk,
  input  logic              strb_n_clk,
  input  logic              fr_clk,
  input  logic              hr_clk,
  input  logic              rst,
  input  logic [DQ_W-1:0]   dq,
  input  logic              skip_align,
  input  logic              skip_resync,
  input  logic              skip_hr,
  input  logic              hr_phase,
  input  logic              sel_fr,
  output logic [4*DQ_W-1:0] q_hr,
  output logic [2*DQ_W-1:0] q_fr
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int PAIR_W = 2 * DQ_W;
  localparam int WORD_W = 2 * PAIR_W;

  // Named internal events, brought out for the bound checker.
  logic [DQ_W-1:0]   rise_raw;
  logic [DQ_W-1:0]   fall_raw;
  logic [DQ_W-1:0]   rise_al;
  logic [DQ_W-1:0]   fall_al;
  logic [PAIR_W-1:0] pair_s;
  logic [PAIR_W-1:0] rs_q;
  logic [PAIR_W-1:0] cur_pair;
  logic [PAIR_W-1:0] hist_new;
  logic [PAIR_W-1:0] hist_old;
  logic [WORD_W-1:0] word;

  ddrc_strobe_capture #(.DQ_W(DQ_W)) u_cap (
    .strb_clk   (strb_clk),
    .strb_n_clk (strb_n_clk),
    .rst        (rst),
    .skip_align (skip_align),
    .dq         (dq),
    .rise_raw   (rise_raw),
    .fall_raw   (fall_raw),
    .rise_al    (rise_al),
    .fall_al    (fall_al),
    .pair_s     (pair_s)
  );

  ddrc_resync #(.DQ_W(DQ_W)) u_rs (
    .fr_clk      (fr_clk),
    .rst         (rst),
    .skip_resync (skip_resync),
    .pair_s      (pair_s),
    .rs_q        (rs_q),
    .cur_pair    (cur_pair)
  );

  ddrc_halfrate #(.DQ_W(DQ_W)) u_hr (
    .fr_clk   (fr_clk),
    .hr_clk   (hr_clk),
    .rst      (rst),
    .skip_hr  (skip_hr),
    .hr_phase (hr_phase),
    .cur_pair (cur_pair),
    .hist_new (hist_new),
    .hist_old (hist_old),
    .word     (word)
  );

  // Runtime steering: the unselected port is held at zero.
  assign q_hr = sel_fr ? '0 : word;
  assign q_fr = sel_fr ? cur_pair : '0;
endmodule

// File: rtl/ddrc_read_capture_chk.sv
module ddrc_read_capture_chk #(
  parameter int DQ_W = 1
) (
  input logic              strb_clk,
  input logic              fr_clk,
  input logic              rst,
  input logic              skip_align,
  input logic              skip_resync,
  input logic [DQ_W-1:0]   rise_raw,
  input logic [DQ_W-1:0]   fall_raw,
  input logic [DQ_W-1:0]   rise_al,
  input logic [DQ_W-1:0]   fall_al,
  input logic [2*DQ_W-1:0] pair_s,
  input logic [2*DQ_W-1:0] rs_q,
  input logic [2*DQ_W-1:0] cur_pair,
  input logic [2*DQ_W-1:0] hist_new,
  input logic [2*DQ_W-1:0] hist_old,
  input logic [4*DQ_W-1:0] q_hr,
  input logic [2*DQ_W-1:0] q_fr
);
  timeunit 1ns;
  timeprecision 1ps;

  logic fr_seen = 1'b0;
  logic st_seen = 1'b0;

  always_ff @(posedge fr_clk)   fr_seen <= 1'b1;
  always_ff @(posedge strb_clk) st_seen <= 1'b1;

  // R8: a reset cycle leaves the full-rate registers empty
  a_r8_fr_cleared: assert property (@(posedge fr_clk)
    rst |=> (rs_q == '0 && hist_new == '0 && hist_old == '0));

  // R1: the aligned rising bit is the one captured a strobe period earlier
  a_r1_rise_aligned: assert property (@(posedge strb_clk) disable iff (rst)
    (st_seen && !$past(rst)) |-> rise_al == $past(rise_raw));

  // R1: the aligned falling bit is the one captured on the last falling edge
  a_r1_fall_aligned: assert property (@(posedge strb_clk) disable iff (rst)
    (st_seen && !$past(rst)) |-> fall_al == $past(fall_raw));

  // R3: with the resync stage in use the pair trails the strobe-side pair by one cycle
  a_r3_resync_delay: assert property (@(posedge fr_clk) disable iff (rst)
    (fr_seen && !$past(rst) && !skip_resync) |-> cur_pair == $past(pair_s));

  // R4: the word history follows the full-rate pair cycle by cycle
  a_r4_history_chain: assert property (@(posedge fr_clk) disable iff (rst)
    (fr_seen && !$past(rst)) |-> (hist_new == $past(cur_pair) && hist_old == $past(hist_new)));

  // R7: never data on both output ports at once
  a_r7_one_port: assert property (@(posedge fr_clk) disable iff (rst)
    (q_fr != '0) |-> (q_hr == '0));

  // R2: alignment skip is static; recorded here so the bench can rely on it
  a_r2_align_static: assert property (@(posedge fr_clk) disable iff (rst)
    (fr_seen && !$past(rst) && skip_align && $past(skip_align) && !skip_resync)
      |-> cur_pair == $past(pair_s));
endmodule

bind ddrc_read_capture ddrc_read_capture_chk #(.DQ_W(DQ_W)) u_chk (
  .strb_clk    (strb_clk),
  .fr_clk      (fr_clk),
  .rst         (rst),
  .skip_align  (skip_align),
  .skip_resync (skip_resync),
  .rise_raw    (rise_raw),
  .fall_raw    (fall_raw),
  .rise_al     (rise_al),
  .fall_al     (fall_al),
  .pair_s      (pair_s),
  .rs_q        (rs_q),
  .cur_pair    (cur_pair),
  .hist_new    (hist_new),
  .hist_old    (hist_old),
  .q_hr        (q_hr),
  .q_fr        (q_fr)
);

// File: tb/test_ddrc_read_capture.sv
module test_ddrc_read_capture;
  timeunit 1ns;
  timeprecision 1ps;

  logic       fr_clk = 1'b0;
  logic       hr_clk = 1'b0;
  logic       strb   = 1'b0;
  logic       strb_n;
  logic       rst    = 1'b1;
  logic [0:0] dq     = 1'b0;
  logic       skip_align  = 1'b0;
  logic       skip_resync = 1'b0;
  logic       skip_hr     = 1'b0;
  logic       hr_phase    = 1'b0;
  logic       sel_fr      = 1'b0;
  logic [3:0] q_hr;
  logic [1:0] q_fr;

  int   checks = 0;
  int   errors = 0;
  int   obs    = 0;
  bit   chk_on = 1'b0;
  logic [1:0] exp_q[$];   // each entry {fall bit, rise bit}, index = pair number

  assign strb_n = ~strb;

  ddrc_read_capture #(.DQ_W(1)) i_ddrc_read_capture (
    .strb_clk    (strb),
    .strb_n_clk  (strb_n),
    .fr_clk      (fr_clk),
    .hr_clk      (hr_clk),
    .rst         (rst),
    .dq          (dq),
    .skip_align  (skip_align),
    .skip_resync (skip_resync),
    .skip_hr     (skip_hr),
    .hr_phase    (hr_phase),
    .sel_fr      (sel_fr),
    .q_hr        (q_hr),
    .q_fr        (q_fr)
  );

  // 250 MHz full-rate clock; half-rate toggles on every full-rate rise.
  initial forever #2 begin
    fr_clk = ~fr_clk;
    if (fr_clk) hr_clk = ~hr_clk;
  end

  // Strobe rises a quarter period after each full-rate edge.
  initial begin
    #3;
    forever begin
      strb = 1'b1; #2;
      strb = 1'b0; #2;
    end
  end

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, expv, $time);
    end
  endtask

  // Driver: puts one pair on DQ, centred on the strobe, and records it.
  task automatic drive_pair(input logic r, input logic f);
    exp_q.push_back({f, r});
    dq = r; #2;
    dq = f; #2;
  endtask

  initial begin
    logic [15:0] lfsr;
    logic r;
    logic f;
    lfsr = 16'hACE1;
    #2;
    forever begin
      r    = lfsr[0];
      lfsr = {lfsr[0] ^ lfsr[2] ^ lfsr[3] ^ lfsr[5], lfsr[15:1]};
      f    = lfsr[0];
      lfsr = {lfsr[0] ^ lfsr[2] ^ lfsr[3] ^ lfsr[5], lfsr[15:1]};
      drive_pair(r, f);
    end
  end

  // Monitor: half a nanosecond before full-rate edge obs.
  initial begin
    #1.5;
    forever begin
      if (chk_on) begin
        int lat;
        int newer;
        lat = (skip_align ? 1 : 2) + (skip_resync ? 0 : 1);
        if (sel_fr) begin
          if (skip_align)       check("R2 full-rate pair", {2'b00, q_fr}, {2'b00, exp_q[obs - lat]});
          else if (skip_resync) check("R3 full-rate pair", {2'b00, q_fr}, {2'b00, exp_q[obs - lat]});
          else                  check("R1 full-rate pair", {2'b00, q_fr}, {2'b00, exp_q[obs - lat]});
          check("R7 half-rate port idle", q_hr, 4'b0000);
        end else if (obs % 2 == 0) begin
          newer = obs - lat - int'(hr_phase) - (skip_hr ? 0 : 2);
          if (skip_hr)       check("R5 word", q_hr, {exp_q[newer], exp_q[newer - 1]});
          else if (hr_phase) check("R6 word", q_hr, {exp_q[newer], exp_q[newer - 1]});
          else               check("R4 word", q_hr, {exp_q[newer], exp_q[newer - 1]});
          check("R7 full-rate port idle", {2'b00, q_fr}, 4'b0000);
        end
      end
      obs++;
      #4;
    end
  end

  // Sequence
  initial begin
    #27.5;
    check("R8 reset half-rate port", q_hr, 4'b0000);
    check("R8 reset full-rate port, sel 0", {2'b00, q_fr}, 4'b0000);
    sel_fr = 1'b1;
    #0.5;
    check("R8 reset full-rate port, sel 1", {2'b00, q_fr}, 4'b0000);
    check("R8 reset half-rate port, sel 1", q_hr, 4'b0000);
    sel_fr = 1'b0;
    #0.5;
    rst = 1'b0;
    #3;
    for (int c = 0; c < 16; c++) begin
      chk_on = 1'b0;
      {hr_phase, skip_hr, skip_resync, skip_align} = 4'(c);
      #(4 * 12);
      chk_on = 1'b1;
      #(4 * 16);
      sel_fr = 1'b1;
      #(4 * 8);
      sel_fr = 1'b0;
    end
    chk_on = 1'b0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  // Watchdog
  initial begin
    #(4 * 20000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual time %0t expected end before it", $time);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule